// File: doc/BRIEF.md
# Large-Immediate Constant Builder

This unit decodes and executes one 48-bit instruction form for a RISC-V style core whose register width is a parameter (32, 64 or 128 bits). The instruction reaches the unit as three 16-bit parcels over a valid/ready handshake. The parcels are joined into one 48-bit word. When that word holds the incremental load-immediate operation, the unit reads the register named in the word. It moves the register value up by exactly 32 bit positions, puts the 32-bit immediate in the vacated low half, and writes the result back to the same register.

The format has only one register field, so the destination is always the source. This is how a full 32-bit immediate fits in 48 bits. Wide constants are built by issuing the instruction several times in a row: once on a 32-bit core, twice on a 64-bit core and four times on a 128-bit core. After that many instructions, none of the register's earlier bits remain.

A word that is not this operation raises a one-cycle illegal-instruction flag and causes no write. A write aimed at register zero is dropped silently.

Top module: `lim_unit`

## Requirements
- R1: The first accepted parcel supplies instruction bits [15:0], the second supplies [31:16] and the third supplies [47:32]. Idle cycles between parcels do not change the result. Decoding uses only the complete 48-bit word.
- R2: After reset, `parcel_rdy_o` is high while parcels are being collected. It is low for exactly the one cycle that follows acceptance of a third parcel. A parcel presented during that cycle is not taken.
- R3: The load-immediate operation is recognised when bits [5:0] = 011111, bit [6] = 0 and bits [15:12] = 1000. The register number is bits [11:7] and the immediate is bits [47:16].
- R4: The written value equals the old register value shifted left by 32, with its low 32 bits replaced by the immediate. For a 32-bit register width, the written value is the immediate alone.
- R5: In the cycle after the third parcel is accepted, the unit drives the register number on `rf_raddr_o`. For a recognised operation, it writes to that same register number in that same cycle, with `rf_we_o` high for one cycle.
- R6: With a 64-bit register width, two operations on one register with immediates 0xCAFED00D and then 0xFEEDBEEF leave 0xCAFED00DFEEDBEEF, whatever the register held before.
- R7: Any other 48-bit word raises `illegal_o` for that one cycle and writes nothing. This covers bits [5:0] other than 011111, bit [6] = 1, and bits [15:12] other than 1000.
- R8: A recognised operation whose register number is 0 writes nothing and does not raise `illegal_o`.
- R9: While reset is asserted, the unit shows `rf_we_o` = 0, `illegal_o` = 0 and `parcel_rdy_o` = 0. The first parcel taken after reset is treated as bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| parcel_i | input | 16 | Instruction parcel |
| parcel_vld_i | input | 1 | Parcel valid |
| parcel_rdy_o | output | 1 | Parcel ready |
| rf_raddr_o | output | 5 | Register-file read address |
| rf_rdata_i | input | XLEN | Register-file read data, combinational from the address |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | XLEN | Register-file write data |
| illegal_o | output | 1 | Illegal-instruction pulse |

## Verification
The assertions assume that the register file answers `rf_raddr_o` within the same cycle. They also assume that `parcel_i` is stable while `parcel_vld_i` is high and the unit has not yet taken the parcel. The bench keeps to both assumptions. Its register-file model is an array read without a clock. It changes parcel data only at falling edges, and only after the previous parcel was seen accepted. It also keeps `parcel_vld_i` high through the write cycles, which exercises the blocked-ready case without breaking those assumptions.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int PARCEL_W = 16;
  localparam int NPARCEL  = 3;
  localparam int INSN_W   = PARCEL_W * NPARCEL;
  localparam int RID_W    = 5;
  localparam int IMM_W    = 32;

  localparam logic [5:0] LEN48_MARK = 6'b011111;
  localparam logic [3:0] FN_LOADIMM = 4'b1000;

  typedef struct packed {
    logic [IMM_W-1:0] imm;
    logic [3:0]       func;
    logic [RID_W-1:0] rid;
    logic             fbit;
    logic [5:0]       len;
  } li_word_t;
endpackage

// File: rtl/lim_rst_sync.sv
module lim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lim_parcel_asm.sv
module lim_parcel_asm #(
  parameter int PW = 16,
  parameter int NP = 3
) (
  input  logic           clk,
  input  logic           rst_sn,
  input  logic [PW-1:0]  parcel_i,
  input  logic           vld_i,
  output logic           rdy_o,
  output logic [PW*NP-1:0] word_o,
  output logic           exec_o
);
  localparam int CW = (NP > 1) ? $clog2(NP) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exec_q, exec_d;
  logic          take;
  logic          last;
  logic [PW-1:0] slot_q [NP];

  assign rdy_o = rst_sn & ~exec_q;
  assign take  = vld_i & rdy_o;
  assign last  = (cnt_q == CW'(NP-1));

  always_comb begin
    cnt_d  = cnt_q;
    exec_d = 1'b0;
    if (take) begin
      if (last) begin
        cnt_d  = '0;
        exec_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cnt_q  <= '0;
      exec_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      exec_q <= exec_d;
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_slot
    logic slot_en;
    assign slot_en = take & (cnt_q == CW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= parcel_i;
    end
    assign word_o[g*PW +: PW] = slot_q[g];
  end

  assign exec_o = exec_q;

  // R2
  exec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    exec_q |=> !exec_q);
  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cnt_q <= CW'(NP-1));
  // R1
  exec_after_last_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    exec_q |-> $past(cnt_q) == CW'(NP-1));
endmodule

// File: rtl/lim_decode.sv
module lim_decode
  import lim_pkg::*;
(
  input  logic [INSN_W-1:0] word_i,
  output logic              legal_o,
  output logic [RID_W-1:0]  rid_o,
  output logic [IMM_W-1:0]  imm_o
);
  li_word_t w;
  logic     is48;
  logic     fn_ok;

  assign w = li_word_t'(word_i);

  always_comb begin
    is48    = (w.len == LEN48_MARK);
    fn_ok   = (w.func == FN_LOADIMM) && !w.fbit;
    legal_o = is48 && fn_ok;
    rid_o   = w.rid;
    imm_o   = w.imm;
  end
endmodule

// File: rtl/lim_exec.sv
module lim_exec #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rs_i,
  input  logic [31:0]     imm_i,
  output logic [XLEN-1:0] res_o
);
  if (XLEN == 32) begin : g_x32
    logic unused_rs;
    assign unused_rs = ^rs_i;
    assign res_o     = imm_i;
  end else begin : g_wide
    assign res_o = {rs_i[XLEN-33:0], imm_i};
  end
endmodule

// File: rtl/lim_unit.sv
module lim_unit
  import lim_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     parcel_i,
  input  logic            parcel_vld_i,
  output logic            parcel_rdy_o,
  output logic [4:0]      rf_raddr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            illegal_o
);
  logic              rst_sn;
  logic [INSN_W-1:0] word;
  logic              exec;
  logic              legal;
  logic [RID_W-1:0]  rid;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   result;

  lim_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn)
  );

  lim_parcel_asm #(.PW(PARCEL_W), .NP(NPARCEL)) u_asm (
    .clk(clk), .rst_sn(rst_sn), .parcel_i(parcel_i), .vld_i(parcel_vld_i),
    .rdy_o(parcel_rdy_o), .word_o(word), .exec_o(exec)
  );

  lim_decode u_dec (
    .word_i(word), .legal_o(legal), .rid_o(rid), .imm_o(imm)
  );

  lim_exec #(.XLEN(XLEN)) u_exe (
    .rs_i(rf_rdata_i), .imm_i(imm), .res_o(result)
  );

  always_comb begin
    rf_raddr_o = rid;
    rf_waddr_o = rid;
    rf_wdata_o = result;
    rf_we_o    = exec && legal && (rid != '0);
    illegal_o  = exec && !legal;
  end

  // R5
  we_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rf_we_o |-> $past(parcel_vld_i && parcel_rdy_o));
  // R2
  rdy_low_exec_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (rf_we_o || illegal_o) |-> !parcel_rdy_o);
  // R8
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rf_we_o |-> rf_waddr_o != 5'd0);
  // R7
  we_illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(rf_we_o && illegal_o));
  // R7
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    illegal_o |=> !illegal_o);
  // R4
  imm_high_half_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    rf_we_o |-> rf_wdata_o[31:16] == $past(parcel_i));
endmodule

// File: tb/lim_unit_test.sv
`timescale 1ns/1ps
module lim_unit_test;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   parcel = 16'h0;
  logic          vld = 1'b0;
  logic          rdy;
  logic [4:0]    raddr, waddr;
  logic [XL-1:0] rdata, wdata;
  logic          we, ill;

  logic [XL-1:0] rf [32];
  assign rdata = rf[raddr];

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic cmp_en = 1'b0;

  logic [15:0] q[$];
  logic        m_exec = 1'b0;
  logic [47:0] m_word = '0;

  always #2.5 clk = ~clk;

  lim_unit #(.XLEN(XL)) uut (
    .clk(clk), .rst_n(rst_n), .parcel_i(parcel), .parcel_vld_i(vld),
    .parcel_rdy_o(rdy), .rf_raddr_o(raddr), .rf_rdata_i(rdata),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata), .illegal_o(ill)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input logic [4:0] rd, input logic [31:0] imm,
                                     input logic [3:0] fn, input logic fb, input logic [5:0] ln);
    return {imm, fn, rd, fb, ln};
  endfunction

  // behavioural reference model and register-file model
  always @(posedge clk) begin
    if (we) rf[waddr] <= wdata;
    if (cmp_en) begin
      if (m_exec) m_exec = 1'b0;
      else if (vld) begin
        q.push_back(parcel);
        if (q.size() == 3) begin
          m_word = {q[2], q[1], q[0]};
          q.delete();
          m_exec = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      logic        lg;
      logic [4:0]  rd;
      logic [XL-1:0] ev;
      lg = (m_word[5:0] == 6'b011111) && !m_word[6] && (m_word[15:12] == 4'b1000);
      rd = m_word[11:7];
      ev = (rf[rd] << 32) | XL'(m_word[47:16]);
      chk("R2 ready", rdy, !m_exec);
      chk("R5 write enable", we, m_exec && lg && rd != 0);
      chk("R7 illegal", ill, m_exec && !lg);
      if (m_exec) chk("R3 read address", raddr, rd);
      if (m_exec && lg && rd != 0) begin
        chk("R5 write address", waddr, rd);
        chk("R4 write data", wdata, ev);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [15:0] p);
    @(negedge clk);
    parcel = p;
    vld = 1'b1;
    while (!rdy) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0;
      parcel = 16'hDEAD;
    end
  endtask

  task automatic send(input logic [47:0] w);
    put(w[15:0]);
    put(w[31:16]);
    put(w[47:32]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = (i == 0) ? '0 : {16{i[3:0]}};
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset we", we, 1'b0);
    chk("R9 reset illegal", ill, 1'b0);
    chk("R9 reset ready", rdy, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ready after reset", rdy, 1'b1);
    cmp_en = 1'b1;

    // R6 build 0xCAFED00DFEEDBEEF on x5 from arbitrary contents
    send(mk(5'd5, 32'hCAFED00D, 4'b1000, 1'b0, 6'b011111));
    send(mk(5'd5, 32'hFEEDBEEF, 4'b1000, 1'b0, 6'b011111));
    idle(2);
    chk("R6 x5 value", rf[5], 64'hCAFED00DFEEDBEEF);

    // R4 single step: old low half moves up
    send(mk(5'd5, 32'h12345678, 4'b1000, 1'b0, 6'b011111));
    idle(2);
    chk("R4 x5 shifted", rf[5], 64'hFEEDBEEF12345678);

    // R1 gaps between parcels
    begin
      logic [47:0] w;
      w = mk(5'd31, 32'hA5A55A5A, 4'b1000, 1'b0, 6'b011111);
      put(w[15:0]);  idle(3);
      put(w[31:16]); idle(1);
      put(w[47:32]); idle(2);
      chk("R1 x31 gapped", rf[31], 64'hFFFFFFFFA5A55A5A);
    end

    // R7 illegal forms
    send(mk(5'd7, 32'h11111111, 4'b0000, 1'b0, 6'b011111));
    send(mk(5'd7, 32'h22222222, 4'b1000, 1'b1, 6'b011111));
    send(mk(5'd7, 32'h33333333, 4'b1000, 1'b0, 6'b011011));
    send(mk(5'd7, 32'h44444444, 4'b1001, 1'b0, 6'b011111));
    idle(2);
    chk("R7 x7 untouched", rf[7], {16{4'h7}});

    // R8 x0 target
    send(mk(5'd0, 32'h99999999, 4'b1000, 1'b0, 6'b011111));
    idle(2);
    chk("R8 x0 zero", rf[0], 64'h0);

    // R2 back-to-back with valid held through write cycles
    send(mk(5'd9, 32'h00000001, 4'b1000, 1'b0, 6'b011111));
    send(mk(5'd9, 32'h00000002, 4'b1000, 1'b0, 6'b011111));
    idle(2);
    chk("R2 x9 back-to-back", rf[9], 64'h0000000100000002);

    cmp_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule